// File: doc/BRIEF.md
# Trace Port Capture Controller

This block records the byte-wide output of an instruction trace port into a frame memory so that a debug host can read it back later. Each accepted sample is one byte: a 3-bit pipeline status in bits 2:0, a 4-bit packet nibble in bits 6:3 and a sync marker in bit 7. Sixteen accepted samples make one frame. Each complete frame goes to a circular frame memory through a simple write port, at the frame address that the block holds.

A host reaches four registers through a register-access front end. These are the frame address, a post-trigger frame count, the control word and a status word. A trigger cycle is a sample whose pipeline-status field carries a reserved code. After the first trigger, the block keeps capturing for the programmed number of frames and then stops by itself. Sticky flags tell the host whether the memory has wrapped. From that the host knows where the oldest valid frame lies: at the current address after a wrap, otherwise at frame zero.

The trace clock is presented as two single-cycle strobes on the system clock, one for its rising edge and one for its falling edge. In full-rate mode only rising strobes take a sample. In half-rate mode both strobes do, so the port is sampled at twice the trace clock rate.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset the address, trigger count, control and status registers read 0 (status bit 3 follows the lock input), and no frame is written.
- R2: Sample k (0..15) of a frame occupies frame-data bits 8k+7:8k. A complete frame is written one cycle after its sixteenth sample, at the value held in the address register (offset 0), and the address then advances by one.
- R3: With control bit 1 clear, only rising-edge strobes take samples; falling-edge strobes have no effect on the stored frames.
- R4: With control bit 1 set, both rising-edge and falling-edge strobes take samples, in arrival order.
- R5: Writing the last frame (FRAMES-1) moves the address to 0 and sets the full flag (status bit 2). The flag stays set until a new capture is enabled.
- R6: A sample whose bits 2:0 equal the trigger code (default 3'b110) sets status bit 1. The frame holding it is written, followed by exactly the programmed count (register offset 1) of further frames. The block then sets status bit 0 (complete), clears control bit 0 and writes nothing more.
- R7: Only the first trigger after a capture starts loads the post-trigger count; later trigger codes do not extend the capture.
- R8: Writing control bit 0 as 0 stops capture at once. A partly filled frame is discarded and no further frames are written.
- R9: Setting control bit 0 while capture is off clears the complete, triggered and full flags and starts a new frame at sample 0. It does not change the address register.
- R10: Status bit 3 reflects the trace clock lock input.
- R11: Register offsets are 0 address, 1 post-trigger count, 2 control (bit 0 enable, bit 1 half-rate), 3 status (bit 0 complete, bit 1 triggered, bit 2 full, bit 3 locked). Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_rise | input | 1 | Strobe: trace clock rising edge this cycle |
| trc_fall | input | 1 | Strobe: trace clock falling edge this cycle |
| trc_data | input | 8 | Trace port byte |
| trc_locked | input | 1 | Trace clock recovery locked |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_we | output | 1 | Frame memory write enable |
| mem_addr | output | AW | Frame memory write address |
| mem_wdata | output | 128 | Frame data, 16 samples |

## Verification
The assertions assume that the host does not write the address register in the same cycle as a frame commit, and that strobes arrive as single-cycle pulses. The stimulus changes registers only between sample bursts, and it never raises a strobe during a register write, so both assumptions hold. The trigger scenarios put trigger codes mid-frame, in the last slot and repeated within one capture, which exercises the loading of the countdown and its end at a frame boundary.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned SMP_W = 8;
  localparam int unsigned SLOTS = 16;
  localparam int unsigned FRAME_W = SMP_W * SLOTS;

  typedef logic [SMP_W-1:0] smp_t;

  localparam logic [2:0] RA_ADDR = 3'd0;
  localparam logic [2:0] RA_TCNT = 3'd1;
  localparam logic [2:0] RA_CTRL = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;

  function automatic logic pstat_is(smp_t b, logic [2:0] code);
    return b[2:0] == code;
  endfunction

  function automatic logic [31:0] status_word(logic done, logic trig,
                                              logic full, logic lock);
    return {28'd0, lock, full, trig, done};
  endfunction
endpackage

// File: rtl/tpc_sampler.sv
module tpc_sampler
  import tpc_pkg::*;
#(
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input  logic run,
  input  logic half,
  input  logic rise,
  input  logic fall,
  input  smp_t din,
  output logic fire,
  output smp_t sample,
  output logic trig_hit
);
  always_comb begin
    fire     = run && (rise || (half && fall));
    sample   = din;
    trig_hit = fire && pstat_is(din, TRIG_CODE);
  end
endmodule

// File: rtl/tpc_packer.sv
module tpc_packer
  import tpc_pkg::*;
#(
  parameter int unsigned NSLOT = SLOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   fire,
  input  smp_t                   din,
  output logic                   frm_done,
  output logic [NSLOT*SMP_W-1:0] frm_data
);
  localparam int unsigned SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  logic [SW-1:0] slot_q;
  smp_t          buf_q [NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      for (int i = 0; i < NSLOT; i++) buf_q[i] <= '0;
    end else if (clr) begin
      slot_q <= '0;
    end else if (fire) begin
      buf_q[slot_q] <= din;
      slot_q        <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  end

  assign frm_done = fire && (slot_q == LAST);

  for (genvar g = 0; g < NSLOT; g++) begin : g_lane
    if (g == NSLOT - 1) begin : g_last
      assign frm_data[g*SMP_W +: SMP_W] = (slot_q == LAST) ? din : buf_q[g];
    end else begin : g_mid
      assign frm_data[g*SMP_W +: SMP_W] = buf_q[g];
    end
  end
endmodule

// File: rtl/tpc_posttrig.sv
module tpc_posttrig #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          trig_hit,
  input  logic          commit,
  input  logic [CW-1:0] tcnt,
  output logic          trig_q,
  output logic          trig_first,
  output logic          stop_now
);
  logic [CW:0] rem_q, rem_base, rem_next;
  logic        armed;

  always_comb begin
    trig_first = trig_hit && !trig_q;
    rem_base   = trig_first ? ({1'b0, tcnt} + (CW+1)'(1)) : rem_q;
    rem_next   = rem_base - (CW+1)'(1);
    armed      = trig_q || trig_first;
    stop_now   = commit && armed && (rem_next == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      rem_q  <= '0;
    end else if (clr) begin
      trig_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      if (trig_first) trig_q <= 1'b1;
      if (commit && armed) rem_q <= rem_next;
      else if (trig_first) rem_q <= rem_base;
    end
  end
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
  import tpc_pkg::*;
#(
  parameter int unsigned FRAMES    = 16,
  parameter int unsigned CW        = 16,
  parameter logic [2:0]  TRIG_CODE = 3'b110,
  localparam int unsigned AW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trc_rise,
  input  logic               trc_fall,
  input  logic [7:0]         trc_data,
  input  logic               trc_locked,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [FRAME_W-1:0] mem_wdata
);
  localparam logic [AW-1:0] LAST_FRM = AW'(FRAMES - 1);

  function automatic logic [AW-1:0] frame_step(logic [AW-1:0] a);
    return (a == LAST_FRM) ? '0 : a + 1'b1;
  endfunction

  logic          run_q, half_q, st_done_q, st_full_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] tcnt_q;

  logic wr_ctrl, addr_wr, start, halt_cmd, pk_clr;
  logic fire, trig_hit, frm_done, commit, stop_now, trig_flag, trig_first;
  smp_t sample;
  logic [FRAME_W-1:0] frm_data;

  assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
  assign addr_wr  = reg_we && (reg_addr == RA_ADDR);
  assign start    = wr_ctrl && reg_wdata[0] && !run_q;
  assign halt_cmd = wr_ctrl && !reg_wdata[0];
  assign pk_clr   = start || halt_cmd;
  assign commit   = frm_done && !halt_cmd;

  tpc_sampler #(.TRIG_CODE(TRIG_CODE)) u_smp (
    .run(run_q), .half(half_q), .rise(trc_rise), .fall(trc_fall),
    .din(trc_data), .fire(fire), .sample(sample), .trig_hit(trig_hit)
  );

  tpc_packer #(.NSLOT(SLOTS)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .fire(fire), .din(sample),
    .frm_done(frm_done), .frm_data(frm_data)
  );

  tpc_posttrig #(.CW(CW)) u_trig (
    .clk(clk), .rst_n(rst_n), .clr(start), .trig_hit(trig_hit && !halt_cmd),
    .commit(commit), .tcnt(tcnt_q), .trig_q(trig_flag),
    .trig_first(trig_first), .stop_now(stop_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= commit;
      if (commit) begin
        mem_addr  <= addr_q;
        mem_wdata <= frm_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      tcnt_q    <= '0;
      run_q     <= 1'b0;
      half_q    <= 1'b0;
      st_done_q <= 1'b0;
      st_full_q <= 1'b0;
    end else begin
      if (addr_wr) addr_q <= reg_wdata[AW-1:0];
      else if (commit) addr_q <= frame_step(addr_q);

      if (reg_we && (reg_addr == RA_TCNT)) tcnt_q <= reg_wdata[CW-1:0];

      if (wr_ctrl) begin
        run_q  <= reg_wdata[0];
        half_q <= reg_wdata[1];
      end else if (stop_now) begin
        run_q <= 1'b0;
      end

      if (start) st_full_q <= 1'b0;
      else if (commit && (addr_q == LAST_FRM)) st_full_q <= 1'b1;

      if (start) st_done_q <= 1'b0;
      else if (stop_now) st_done_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_ADDR: reg_rdata = 32'(addr_q);
      RA_TCNT: reg_rdata = 32'(tcnt_q);
      RA_CTRL: reg_rdata = {30'd0, half_q, run_q};
      RA_STAT: reg_rdata = status_word(st_done_q, trig_flag, st_full_q, trc_locked);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int unsigned FRAMES = 16,
  parameter int unsigned AW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_q,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] addr_q,
  input logic          addr_wr,
  input logic          start,
  input logic          st_full_q,
  input logic          st_done_q,
  input logic          trig_flag
);
  localparam logic [AW-1:0] LASTA = AW'(FRAMES - 1);

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] a);
    return (a == LASTA) ? '0 : a + 1'b1;
  endfunction

  p_no_write_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !mem_we);

  p_addr_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(addr_wr)) |-> (addr_q == nxt(mem_addr)));

  p_full_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full_q && !start) |=> st_full_q);

  p_done_after_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_done_q |-> trig_flag);

  p_done_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done_q) |-> !run_q);

  p_trig_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_flag && !start) |=> trig_flag);

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!st_full_q && !st_done_q && !trig_flag));
endmodule

bind trace_capture_ctrl tpc_checker #(.FRAMES(FRAMES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .mem_we(mem_we),
  .mem_addr(mem_addr), .addr_q(addr_q), .addr_wr(addr_wr), .start(start),
  .st_full_q(st_full_q), .st_done_q(st_done_q), .trig_flag(trig_flag)
);

// File: tb/test_trace_capture_ctrl.sv
module test_trace_capture_ctrl;
  localparam int FR = 16;
  localparam int AWB = 4;

  logic clk = 0, rst_n = 0;
  logic trc_rise = 0, trc_fall = 0, trc_locked = 0, reg_we = 0;
  logic [7:0] trc_data = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_we;
  logic [AWB-1:0] mem_addr;
  logic [127:0] mem_wdata;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  trace_capture_ctrl i_trace_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .trc_rise(trc_rise), .trc_fall(trc_fall),
    .trc_data(trc_data), .trc_locked(trc_locked), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // scoreboard
  typedef struct packed { logic [AWB-1:0] a; logic [127:0] d; } item_t;
  item_t exp_q[$];
  logic [127:0] m_frame;
  int m_slot = 0, m_addr = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model_take(input logic [7:0] b);
    m_frame[m_slot*8 +: 8] = b;
    m_slot++;
    if (m_slot == 16) begin
      exp_q.push_back('{a: AWB'(m_addr), d: m_frame});
      m_addr = (m_addr + 1) % FR;
      m_slot = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(0, "R6/R8 unexpected frame write", longint'(mem_addr), 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.a, "R2 frame address", longint'(mem_addr), longint'(e.a));
        check(mem_wdata == e.d, "R2/R3/R4 frame data",
              longint'(mem_wdata[63:0]), longint'(e.d[63:0]));
      end
    end
  end

  task automatic tick(input logic r, input logic f, input logic [7:0] d);
    @(negedge clk);
    reg_we = 0; trc_rise = r; trc_fall = f; trc_data = d;
  endtask

  task automatic sample(input logic [7:0] b, input bit take);
    tick(1, 0, b);
    if (take) model_take(b);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    trc_rise = 0; trc_fall = 0;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_check(input logic [2:0] a, input logic [31:0] expv, input string req);
    @(negedge clk);
    trc_rise = 0; trc_fall = 0; reg_we = 0; reg_addr = a;
    #1;
    check(reg_rdata == expv, req, longint'(reg_rdata), longint'(expv));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 8'h00);
  endtask

  task automatic begin_capture(input int a, input int tc, input logic [31:0] ctrl);
    reg_write(3'd2, 32'd0);
    reg_write(3'd0, 32'(a));
    reg_write(3'd1, 32'(tc));
    reg_write(3'd2, ctrl);
    m_slot = 0; m_addr = a;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    reg_check(3'd0, 0, "R1 address after reset");
    reg_check(3'd1, 0, "R1 count after reset");
    reg_check(3'd2, 0, "R1 control after reset");
    reg_check(3'd3, 0, "R1 status after reset");
    check(mem_we == 0, "R1 no write after reset", longint'(mem_we), 0);

    // R2/R3 full rate, falling strobes ignored
    begin_capture(0, 100, 32'd1);
    reg_check(3'd1, 100, "R11 count readback");
    reg_check(3'd2, 1, "R11 control readback");
    for (int i = 0; i < 32; i++) begin
      sample(8'((i * 8) | 1), 1);
      tick(0, 1, 8'hA7);
    end
    idle(3);
    reg_check(3'd0, 2, "R2 address advanced by two frames");
    reg_check(3'd3, 0, "R3 status during plain capture");

    // R8 halt mid-frame
    for (int i = 0; i < 5; i++) sample(8'h11, 0);
    reg_write(3'd2, 32'd0);
    for (int i = 0; i < 20; i++) sample(8'h21, 0);
    idle(2);
    reg_check(3'd2, 0, "R8 control after halt");
    reg_check(3'd3, 0, "R8 no complete after halt");
    reg_check(3'd0, 2, "R8 address unchanged after halt");

    // R5 wrap, start at address 2, frame restarts at slot 0 (R9)
    reg_write(3'd2, 32'd1);
    m_slot = 0; m_addr = 2;
    for (int i = 0; i < 13 * 16; i++) sample(8'((i * 8) | 2), 1);
    idle(2);
    reg_check(3'd3, 0, "R5 no full before wrap");
    reg_check(3'd0, 15, "R5 address at last frame");
    for (int i = 0; i < 2 * 16; i++) sample(8'((i * 16) | 3), 1);
    idle(2);
    reg_check(3'd3, 4, "R5 full after wrap");
    reg_check(3'd0, 1, "R5 address wrapped");
    idle(4);
    reg_check(3'd3, 4, "R5 full stays set");

    // R9 restart clears flags, keeps address
    reg_write(3'd2, 32'd0);
    reg_write(3'd2, 32'd1);
    reg_check(3'd3, 0, "R9 flags cleared on new capture");
    reg_check(3'd0, 1, "R9 address kept on new capture");

    // R6/R7 trigger with count 2, second trigger ignored
    begin_capture(0, 2, 32'd1);
    for (int f = 0; f < 6; f++)
      for (int s = 0; s < 16; s++) begin
        logic [7:0] b;
        b = 8'((f * 16 + s) << 3) | 8'h01;
        if ((f == 1 && s == 5) || (f == 2 && s == 9)) b = {b[7:3], 3'b110};
        sample(b, f < 4);
      end
    idle(3);
    reg_check(3'd3, 3, "R6 complete and triggered");
    reg_check(3'd2, 0, "R6 enable cleared");
    reg_check(3'd0, 4, "R7 exactly trigger frame plus two");

    // R6 zero count, trigger in last slot
    begin_capture(0, 0, 32'd1);
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 16; s++) begin
        logic [7:0] b;
        b = 8'((f * 16 + s) << 3) | 8'h04;
        if (f == 1 && s == 15) b = {b[7:3], 3'b110};
        sample(b, f < 2);
      end
    idle(3);
    reg_check(3'd3, 3, "R6 zero count stops at trigger frame");
    reg_check(3'd0, 2, "R6 zero count address");

    // R4 half rate, R10 lock
    begin_capture(0, 5, 32'd3);
    for (int i = 0; i < 16; i++) begin
      tick(1, 0, 8'((i * 8) | 1)); model_take(8'((i * 8) | 1));
      tick(0, 1, 8'((i * 8) | 5)); model_take(8'((i * 8) | 5));
    end
    idle(3);
    reg_check(3'd0, 2, "R4 two frames in half rate");
    reg_check(3'd2, 3, "R11 half-rate control readback");
    trc_locked = 1;
    reg_check(3'd3, 8, "R10 lock bit");
    trc_locked = 0;
    reg_check(3'd3, 0, "R10 lock bit clear");

    idle(5);
    check(exp_q.size() == 0, "R2 all expected frames written", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule